// File: doc/BRIEF.md
# PWM Input Period Capture

This block times a pulse-width-modulated waveform. A 3-bit select picks one of eight candidate inputs. The chosen line is brought into the clock domain by a two-flop synchroniser, and its rising and falling transitions are detected there. The block is clocked at 100 MHz, so every count is worth 10 ns.

Three values are kept in registers for software to read:
- the duration of the last complete high phase;
- the duration of the last complete low phase;
- the number of cycles since the most recent transition.

A single capture unit is shared by every PWM channel, so all channels read the same three values.

A rising transition stores the running count as the low duration. A falling transition stores it as the high duration. Either transition restarts the running count at one. After reset, and after any change of the select, the block has no reference point. It clears its results and waits for a transition before it starts counting. The phase that this first transition ends was only partly seen, so it is never reported. All counters hold at their maximum value rather than wrapping.

Top module: `pwm_period_capture`

## Requirements
- R1: While reset is asserted and just after it is released, `low_len`, `high_len` and `since_edge` all read 0.
- R2: A rising transition of the selected input stores the number of clock cycles the input was low in `low_len`.
- R3: A falling transition of the selected input stores the number of clock cycles the input was high in `high_len`.
- R4: After a transition, `since_edge` reads 1 three cycles after the input changed, counting the two synchroniser flops and the edge register. It then rises by one every cycle.
- R5: Until the first transition after reset or after a select change, `since_edge` stays at 0. The phase that the first transition ends is not stored.
- R6: `src_sel` value k (0 to 7) picks `pwm_in[k]`. Activity on the other bits has no effect.
- R7: A change of `src_sel` clears all three outputs at the next clock. For the two cycles it takes the new input to pass through the synchroniser, level differences are not treated as transitions.
- R8: Every count saturates at 2^CNT_W - 1 and never wraps.
- R9: A phase lasting a single clock cycle is measured as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock, 10 ns per count |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Index of the input to measure |
| pwm_in | input | 8 | Candidate PWM inputs, asynchronous |
| low_len | output | CNT_W | Last complete low phase in cycles |
| high_len | output | CNT_W | Last complete high phase in cycles |
| since_edge | output | CNT_W | Cycles since the last transition |

## Verification
The bench checks phase lengths of one cycle and of several cycles. An off-by-one in the count or a skipped latch would show up as a length one away from the expected value, or as a value left over from an earlier phase.

It switches the select while the old and new inputs sit at different levels. A design without the flush window would record a false transition and begin counting.

It checks that the partial first phase is not stored. It also holds phases long enough on a narrow instance to show that counts stop at the maximum instead of wrapping back to small numbers.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } pic_event_e;

    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pic_edge_front.sv
module pic_edge_front
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src_in,
    output pic_event_e         ev,
    output logic               sel_change
);
    localparam int unsigned FLUSH_W = $clog2(SYNC_STAGES + 1);

    typedef struct packed {
        logic               sync1;
        logic               sync2;
        logic               prev;
        logic [SEL_W-1:0]   sel;
        logic [FLUSH_W-1:0] flush;
    } front_t;

    front_t st_q, st_d;
    logic   picked;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) picked = src_in[i];
        end
    end

    always_comb begin
        st_d       = st_q;
        sel_change = (sel != st_q.sel);
        st_d.sync1 = picked;
        st_d.sync2 = st_q.sync1;
        st_d.prev  = st_q.sync2;
        st_d.sel   = sel;
        if (sel_change)
            st_d.flush = FLUSH_W'(SYNC_STAGES);
        else if (st_q.flush != '0)
            st_d.flush = st_q.flush - 1'b1;

        ev = EV_NONE;
        if (!sel_change && st_q.flush == '0) begin
            if (st_q.sync2 && !st_q.prev)
                ev = EV_RISE;
            else if (!st_q.sync2 && st_q.prev)
                ev = EV_FALL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.sel <= sel;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pic_phase_timer.sv
module pic_phase_timer
    import pic_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pic_event_e       ev,
    input  logic             clear,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len,
    output logic [CNT_W-1:0] since_edge
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
    } timer_t;

    timer_t st_q, st_d;
    logic [CNT_W-1:0] run_inc;

    always_comb begin
        run_inc = (st_q.run == CNT_MAX) ? st_q.run : st_q.run + 1'b1;
        st_d    = st_q;
        if (clear) begin
            st_d = '0;
        end else if (ev != EV_NONE) begin
            if (st_q.armed) begin
                if (ev == EV_RISE) st_d.low  = st_q.run;
                else               st_d.high = st_q.run;
            end
            st_d.armed = 1'b1;
            st_d.run   = CNT_W'(1);
        end else if (st_q.armed) begin
            st_d.run = run_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign low_len    = st_q.low;
    assign high_len   = st_q.high;
    assign since_edge = st_q.run;
endmodule

// File: rtl/pwm_period_capture.sv
module pwm_period_capture
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned CNT_W   = 24,
    localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NUM_SRC-1:0] pwm_in,
    output logic [CNT_W-1:0]   low_len,
    output logic [CNT_W-1:0]   high_len,
    output logic [CNT_W-1:0]   since_edge
);
    pic_event_e ev;
    logic       sel_change;

    pic_edge_front #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (src_sel),
        .src_in     (pwm_in),
        .ev         (ev),
        .sel_change (sel_change)
    );

    pic_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .clear      (sel_change),
        .low_len    (low_len),
        .high_len   (high_len),
        .since_edge (since_edge)
    );
endmodule

// File: rtl/pic_capture_checker.sv
module pic_capture_checker #(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] src_sel,
    input logic [CNT_W-1:0] low_len,
    input logic [CNT_W-1:0] high_len,
    input logic [CNT_W-1:0] since_edge
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_sel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_sel) |=> (low_len == '0 && high_len == '0 && since_edge == '0));

    assert_low_from_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(low_len) |-> (low_len == '0 || low_len == $past(since_edge)));

    assert_high_from_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(high_len) |-> (high_len == '0 || high_len == $past(since_edge)));

    assert_start_at_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_edge == '0) |=> (since_edge <= CNT_W'(1)));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_edge == CNT_MAX) |=> (since_edge == CNT_MAX || since_edge <= CNT_W'(1)));
endmodule

bind pwm_period_capture pic_capture_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .low_len    (low_len),
    .high_len   (high_len),
    .since_edge (since_edge)
);

// File: tb/pwm_period_capture_test.sv
module pwm_period_capture_test;
    localparam int CW  = 24;
    localparam int CWS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    sel = 3'd0;
    logic [7:0]    pwm = 8'h00;
    logic [2:0]    sel_s = 3'd0;
    logic [7:0]    pwm_s = 8'h00;
    logic [CW-1:0]  lo, hi, se;
    logic [CWS-1:0] lo_s, hi_s, se_s;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pwm_period_capture #(.NUM_SRC(8), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .src_sel(sel), .pwm_in(pwm),
        .low_len(lo), .high_len(hi), .since_edge(se)
    );

    pwm_period_capture #(.NUM_SRC(8), .CNT_W(CWS)) uut_sat (
        .clk(clk), .rst_n(rst_n), .src_sel(sel_s), .pwm_in(pwm_s),
        .low_len(lo_s), .high_len(hi_s), .since_edge(se_s)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // wait n rising edges, end at a falling edge
    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        hold(3);
        check("R1", "low in reset", lo, 0);
        check("R1", "high in reset", hi, 0);
        check("R1", "since in reset", se, 0);
        rst_n = 1'b1;
        hold(5);
        check("R5", "since before edge", se, 0);
        check("R1", "low after release", lo, 0);
    endtask

    task automatic t_first_edge;
        pwm[0] = 1'b1; hold(6);
        check("R5", "partial low not stored", lo, 0);
        pwm[0] = 1'b0; hold(4);
        check("R3", "high 6", hi, 6);
        check("R5", "low still empty", lo, 0);
    endtask

    task automatic t_periods;
        pwm[0] = 1'b1; hold(10);
        check("R2", "low 4", lo, 4);
        pwm[0] = 1'b0; hold(13);
        check("R3", "high 10", hi, 10);
        pwm[0] = 1'b1; hold(5);
        check("R2", "low 13", lo, 13);
    endtask

    task automatic t_since;
        pwm[0] = 1'b0; hold(3);
        check("R4", "since at first count", se, 1);
        check("R3", "high 5", hi, 5);
        hold(7);
        check("R4", "since after 10", se, 8);
    endtask

    task automatic t_narrow;
        pwm[0] = 1'b1; hold(1);
        pwm[0] = 1'b0; hold(6);
        pwm[0] = 1'b1; hold(1);
        pwm[0] = 1'b0; hold(6);
        check("R9", "one-cycle high", hi, 1);
        check("R2", "low 6 between pulses", lo, 6);
    endtask

    task automatic t_src_switch;
        pwm[3] = 1'b1;
        sel = 3'd3; hold(1);
        check("R7", "low cleared", lo, 0);
        check("R7", "high cleared", hi, 0);
        check("R7", "since cleared", se, 0);
        pwm[0] = 1'b1; hold(10);
        check("R7", "no false edge", se, 0);
        check("R6", "other input ignored", lo, 0);
        pwm[3] = 1'b0; hold(7);
        pwm[0] = 1'b0;
        pwm[3] = 1'b1; hold(4);
        check("R6", "low of input 3", lo, 7);
        check("R4", "since on input 3", se, 2);
    endtask

    task automatic t_saturate;
        pwm_s[0] = 1'b1; hold(3);
        pwm_s[0] = 1'b0; hold(100);
        pwm_s[0] = 1'b1; hold(80);
        check("R8", "since saturates", se_s, 63);
        check("R8", "low saturates", lo_s, 63);
        pwm_s[0] = 1'b0; hold(4);
        check("R8", "high saturates", hi_s, 63);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_edge();
        t_periods();
        t_since();
        t_narrow();
        t_src_switch();
        t_saturate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule